// File: doc/BRIEF.md
# Serial Memory Power-State Controller

This block is the power-state sequencer on the device side of a serial memory that sits on an SPI bus. It watches the chip-select, serial clock and serial data input. It tracks whether the device is selected, idle, going into one of two deep sleep levels, asleep, or waking. A host drops the device into the lighter deep level (power-down) or the deepest level (hibernate) by sending a one-byte command and then deselecting. The device then goes through a timed entry phase and stays asleep until the wake condition for that level is seen. It then runs a timed wake phase before it accepts traffic again.

All timing is counted in clock cycles of `clk`. The serial pins are assumed to be synchronous to `clk` already. The two sleep opcodes, both entry times, both wake times and the minimum select-low width that wakes power-down are parameters. The outputs give the present state code, a ready flag, and a gate that tells the command decoder to refuse traffic while a wake phase runs.

Top module: `pmc_power_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, the state code is 1 (idle), `ready` is 1 and `cmd_block` is 0. A reset from any state returns the block to idle.
- R2: The state codes are: 0 selected, 1 idle, 2 power-down entry, 3 power-down, 4 power-down wake, 5 hibernate entry, 6 hibernate, 7 hibernate wake. A falling `cs_n` seen in idle moves the state to 0 at that clock edge, and `ready` stays 1.
- R3: A rising `cs_n` in state 0 returns the block to idle unless a complete sleep opcode was received. This covers a partial byte of 0 to 7 bits and any complete byte that is not one of the two sleep opcodes.
- R4: A command byte is taken MSB first, one bit on each rising `sck` while selected. If that byte equals `OP_DPD`, the next rising `cs_n` enters state 2. The block stays in state 2 for exactly `DPD_ENTER_CYC` cycles and then moves to state 3.
- R5: If the command byte equals `OP_HIB`, the next rising `cs_n` enters state 5. The block stays in state 5 for exactly `HIB_ENTER_CYC` cycles and then moves to state 6.
- R6: `ready` is 1 only in states 0 and 1. `cmd_block` is 1 only in states 4 and 7.
- R7: In state 3, the block moves to state 4 only when `cs_n` has been sampled low on `DPD_PULSE_CYC` consecutive clock edges. It moves at the last of those edges. A shorter low pulse leaves the state at 3.
- R8: State 4 lasts exactly `DPD_WAKE_CYC` cycles and then returns to idle.
- R9: In state 6, any falling `cs_n` moves the state to 7 at that edge. State 7 lasts exactly `HIB_WAKE_CYC` cycles and then returns to idle.
- R10: Activity on `cs_n` and `sck` during entry and wake phases has no effect on the timing. After a wake phase, state 0 is reached only through a new falling `cs_n`. If `cs_n` is held low through the wake phase, the block stays idle.
- R11: Only the first eight bits after select form the command. Further bits in the same select have no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to `clk` |
| sck | input | 1 | Serial clock; data is taken on its rising edge |
| si | input | 1 | Serial data in, MSB first |
| pstate | output | 3 | Present power-state code (see R2) |
| ready | output | 1 | High when the device can be accessed |
| cmd_block | output | 1 | High while a wake phase runs; new commands must be refused |

## Verification
The assertions assume that the serial pins are already synchronous to `clk`. Each level of `sck` must last at least one clock, so that every rising edge is seen once. `cs_n` must not change in the same cycle as a rising `sck`. The stimulus changes all inputs only on the falling clock edge. It uses a serial clock of four cycles with two cycles high and two low, and it moves `cs_n` only while `sck` is low.

The sweep covers every value of the command byte, every partial length, and every power-down wake pulse width up to the threshold. It also covers select toggling inside the entry and wake windows and a select held low through a wake phase.

// File: rtl/pmc_pkg.sv
// Package: power-state codes and helpers shared by the controller and its checker.
// Assumes: the 3-bit code values are visible at the pstate port and must stay fixed.
package pmc_pkg;

    typedef enum logic [2:0] {
        PS_ACTIVE    = 3'd0,
        PS_STANDBY   = 3'd1,
        PS_DPD_ENTER = 3'd2,
        PS_DPD       = 3'd3,
        PS_DPD_WAKE  = 3'd4,
        PS_HIB_ENTER = 3'd5,
        PS_HIB       = 3'd6,
        PS_HIB_WAKE  = 3'd7
    } pstate_t;

    // True when the device accepts an access in state s.
    function automatic logic is_ready(input pstate_t s);
        return (s == PS_ACTIVE) || (s == PS_STANDBY);
    endfunction

    // True while a wake phase runs and commands must be refused.
    function automatic logic is_waking(input pstate_t s);
        return (s == PS_DPD_WAKE) || (s == PS_HIB_WAKE);
    endfunction

    // Largest of four cycle counts, used to size the shared timer.
    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/pmc_edge_detect.sv
// Module: edge detector for the serial pins.
// Registers chip-select and serial clock once. It flags rising and falling
// select and rising serial clock in the cycle where the new level is first seen.
// Assumes: inputs are already synchronous to clk. After reset, select is taken as
// high and the serial clock as high, so no false edge is flagged.
module pmc_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic cs_rise,
    output logic cs_fall,
    output logic sck_rise
);

    logic cs_q;
    logic sck_q;

    // Hold the previous level of each pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b1;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
        end
    end

    // Compare the present level with the previous one.
    always_comb begin
        cs_rise  = ~cs_q & cs_n;
        cs_fall  = cs_q & ~cs_n;
        sck_rise = ~sck_q & sck;
    end

endmodule

// File: rtl/pmc_cmd_shift.sv
// Module: command byte receiver.
// Shifts serial data MSB first on each flagged rising serial clock while enabled.
// It keeps only the first OP_W bits of a select and flags a complete match
// against either sleep opcode.
// Assumes: clear is held high between selects (select high), which drops a partial byte.
module pmc_cmd_shift #(
    parameter int          OP_W = 8,
    parameter logic [7:0]  OP_A = 8'hB9,
    parameter logic [7:0]  OP_B = 8'hBA
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic sck_rise,
    input  logic si,
    output logic hit_a,
    output logic hit_b
);

    localparam int CW = $clog2(OP_W + 1);

    logic [OP_W-1:0] shreg;
    logic [CW-1:0]   nbits;
    logic            full;

    // Capture up to OP_W bits per select; later bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            nbits <= '0;
        end else if (clear) begin
            nbits <= '0;
        end else if (enable && sck_rise && !full) begin
            shreg <= {shreg[OP_W-2:0], si};
            nbits <= nbits + 1'b1;
        end
    end

    // Decode a complete byte against the two opcodes.
    always_comb begin
        full  = (nbits == CW'(OP_W));
        hit_a = full && (shreg == OP_A[OP_W-1:0]);
        hit_b = full && (shreg == OP_B[OP_W-1:0]);
    end

endmodule

// File: rtl/pmc_timer.sv
// Module: shared countdown timer for entry and wake phases.
// load sets the count. It then counts down to zero and holds there.
// done is high whenever the count is zero.
// Assumes: a phase of N cycles is loaded with N-1 on the edge that enters it.
module pmc_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt;

    // Load or count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Flag the end of the phase.
    always_comb done = (cnt == '0);

endmodule

// File: rtl/pmc_pulse_meter.sv
// Module: select-low width meter for the power-down wake.
// Counts consecutive low samples of select while armed. reached is flagged on
// the edge that gives the LIM-th low sample.
// Assumes: LIM >= 1. Disarming or a high sample restarts the count.
module pmc_pulse_meter #(
    parameter int LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic low,
    output logic reached
);

    localparam int CW = (LIM < 2) ? 1 : $clog2(LIM);

    logic [CW-1:0] cnt;

    // Track the run of low samples; saturate one below the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!arm || !low) begin
            cnt <= '0;
        end else if (cnt != CW'(LIM - 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // This sample completes the required width.
    always_comb reached = arm && low && (cnt == CW'(LIM - 1));

endmodule

// File: rtl/pmc_power_ctrl.sv
// Module: power-state controller for a serial memory slave (top).
// It sequences idle, selected, power-down and hibernate states with timed
// entry and wake phases. It reports the state, a ready flag and a command gate.
// Assumes: cs_n, sck and si are synchronous to clk, and every cycle count parameter is >= 1.
module pmc_power_ctrl #(
    parameter logic [7:0] OP_DPD        = 8'hB9,
    parameter logic [7:0] OP_HIB        = 8'hBA,
    parameter int         DPD_ENTER_CYC = 750,
    parameter int         HIB_ENTER_CYC = 750,
    parameter int         DPD_WAKE_CYC  = 37500,
    parameter int         HIB_WAKE_CYC  = 1250000,
    parameter int         DPD_PULSE_CYC = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    output logic [2:0] pstate,
    output logic       ready,
    output logic       cmd_block
);

    import pmc_pkg::*;

    localparam int TMAX = max4(DPD_ENTER_CYC, HIB_ENTER_CYC, DPD_WAKE_CYC, HIB_WAKE_CYC);
    localparam int TW   = $clog2(TMAX + 1);

    pstate_t       st;
    pstate_t       nxt;
    logic          cs_rise;
    logic          cs_fall;
    logic          sck_rise;
    logic          hit_dpd;
    logic          hit_hib;
    logic          t_load;
    logic [TW-1:0] t_val;
    logic          t_done;
    logic          pulse_ok;

    pmc_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sck_rise (sck_rise)
    );

    pmc_cmd_shift #(
        .OP_W (8),
        .OP_A (OP_DPD),
        .OP_B (OP_HIB)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cs_n),
        .enable   (st == PS_ACTIVE),
        .sck_rise (sck_rise),
        .si       (si),
        .hit_a    (hit_dpd),
        .hit_b    (hit_hib)
    );

    pmc_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    pmc_pulse_meter #(
        .LIM (DPD_PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (st == PS_DPD),
        .low     (~cs_n),
        .reached (pulse_ok)
    );

    // Next-state and timer-load decision.
    always_comb begin
        nxt    = st;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st)
            PS_STANDBY: begin
                if (cs_fall) nxt = PS_ACTIVE;
            end
            PS_ACTIVE: begin
                if (cs_rise) begin
                    if (hit_dpd) begin
                        nxt    = PS_DPD_ENTER;
                        t_load = 1'b1;
                        t_val  = TW'(DPD_ENTER_CYC - 1);
                    end else if (hit_hib) begin
                        nxt    = PS_HIB_ENTER;
                        t_load = 1'b1;
                        t_val  = TW'(HIB_ENTER_CYC - 1);
                    end else begin
                        nxt = PS_STANDBY;
                    end
                end
            end
            PS_DPD_ENTER: begin
                if (t_done) nxt = PS_DPD;
            end
            PS_DPD: begin
                if (pulse_ok) begin
                    nxt    = PS_DPD_WAKE;
                    t_load = 1'b1;
                    t_val  = TW'(DPD_WAKE_CYC - 1);
                end
            end
            PS_DPD_WAKE: begin
                if (t_done) nxt = PS_STANDBY;
            end
            PS_HIB_ENTER: begin
                if (t_done) nxt = PS_HIB;
            end
            PS_HIB: begin
                if (cs_fall) begin
                    nxt    = PS_HIB_WAKE;
                    t_load = 1'b1;
                    t_val  = TW'(HIB_WAKE_CYC - 1);
                end
            end
            PS_HIB_WAKE: begin
                if (t_done) nxt = PS_STANDBY;
            end
            default: nxt = PS_STANDBY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PS_STANDBY;
        else        st <= nxt;
    end

    // Port decode of the state.
    always_comb begin
        pstate    = st;
        ready     = is_ready(st);
        cmd_block = is_waking(st);
    end

endmodule

// File: rtl/pmc_power_ctrl_chk.sv
// Module: property checker for the power-state controller, bound to the top.
// Assumes: serial inputs synchronous to clk; every $past use is guarded by the
// reset level of the previous cycle.
module pmc_power_ctrl_chk #(
    parameter int PULSE_CYC = 100
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic [2:0] pstate,
    input logic       ready,
    input logic       cmd_block
);

    localparam int RW = $clog2(PULSE_CYC + 1);

    logic [RW-1:0] low_run;

    // Independent count of consecutive low select samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                          low_run <= '0;
        else if (cs_n)                       low_run <= '0;
        else if (low_run != RW'(PULSE_CYC))  low_run <= low_run + 1'b1;
    end

    AST_IDLE_SELECT_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pstate == 3'd1 && !cs_n && $past(cs_n)) |=> (pstate == 3'd0)); // R2

    AST_DESELECT_LEAVES_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pstate == 3'd0 && cs_n && !$past(cs_n)) |=>
        (pstate == 3'd1 || pstate == 3'd2 || pstate == 3'd5)); // R3

    AST_DPD_ENTRY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pstate == 3'd2) |-> ($past(pstate) == 3'd0 || $past(pstate) == 3'd2)); // R4

    AST_HIB_ENTRY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pstate == 3'd5) |-> ($past(pstate) == 3'd0 || $past(pstate) == 3'd5)); // R5

    AST_NOT_READY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate >= 3'd2) |-> !ready); // R6

    AST_BLOCK_ONLY_WAKING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_block |-> (pstate == 3'd4 || pstate == 3'd7)); // R6

    AST_DPD_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pstate) == 3'd3 && pstate == 3'd4) |->
        ($past(low_run) >= RW'(PULSE_CYC - 1))); // R7

    AST_DPD_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pstate) == 3'd4) |-> (pstate == 3'd4 || pstate == 3'd1)); // R8

    AST_HIB_WAKE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pstate == 3'd6 && !cs_n && $past(cs_n)) |=> (pstate == 3'd7)); // R9

    AST_HIB_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pstate) == 3'd7) |-> (pstate == 3'd7 || pstate == 3'd1)); // R9

    AST_SEL_NEEDS_IDLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && pstate == 3'd0 && $past(pstate) != 3'd0) |->
        ($past(pstate) == 3'd1 && !$past(cs_n))); // R10

endmodule

bind pmc_power_ctrl pmc_power_ctrl_chk #(
    .PULSE_CYC (DPD_PULSE_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .pstate    (pstate),
    .ready     (ready),
    .cmd_block (cmd_block)
);

// File: tb/pmc_power_ctrl_test.sv
`timescale 1ns/1ps
module pmc_power_ctrl_test;

    localparam logic [7:0] OPD = 8'hB9;
    localparam logic [7:0] OPH = 8'hBA;
    localparam int ENT_D = 5;
    localparam int ENT_H = 6;
    localparam int WK_D  = 12;
    localparam int WK_H  = 20;
    localparam int PULSE = 4;

    // State codes as given in R2.
    localparam int S_SEL = 0, S_IDLE = 1, S_DEN = 2, S_DPD = 3, S_DWK = 4;
    localparam int S_HEN = 5, S_HIB = 6, S_HWK = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic [2:0] pstate;
    logic       ready;
    logic       cmd_block;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    pmc_power_ctrl #(
        .OP_DPD        (OPD),
        .OP_HIB        (OPH),
        .DPD_ENTER_CYC (ENT_D),
        .HIB_ENTER_CYC (ENT_H),
        .DPD_WAKE_CYC  (WK_D),
        .HIB_WAKE_CYC  (WK_H),
        .DPD_PULSE_CYC (PULSE)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .si        (si),
        .pstate    (pstate),
        .ready     (ready),
        .cmd_block (cmd_block)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // State plus the flags R6 derives from it.
    task automatic chk_state(input string tag, input int exp);
        int er;
        int eb;
        er = (exp <= 1) ? 1 : 0;
        eb = (exp == S_DWK || exp == S_HWK) ? 1 : 0;
        check(int'(pstate) == exp, tag, int'(pstate), exp);
        check(int'(ready) == er, "R6 ready", int'(ready), er);
        check(int'(cmd_block) == eb, "R6 cmd_block", int'(cmd_block), eb);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            si = b[7-i];
            sck = 1'b0;
            tick(); tick();
            sck = 1'b1;
            tick(); tick();
        end
        sck = 1'b0;
        tick();
    endtask

    // Called just after the edge that entered a timed state of len cycles.
    task automatic ride(input string tag, input int st_now, input int len, input int st_next);
        chk_state(tag, st_now);
        for (int i = 1; i < len; i++) begin
            tick();
            chk_state(tag, st_now);
        end
        tick();
        chk_state(tag, st_next);
    endtask

    // Select, send a byte, deselect; ends just after the deselect edge.
    task automatic command(input logic [7:0] op);
        cs_n = 1'b0;
        tick();
        chk_state("R2 select", S_SEL);
        send_bits(op, 8);
        cs_n = 1'b1;
        tick();
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        tick(); tick();
        chk_state("R1 in reset", S_IDLE);
        rst_n = 1'b1;
        tick();
        chk_state("R1 after reset", S_IDLE);

        // Full opcode sweep: R3, R4, R5, R7, R8, R9.
        for (int op = 0; op < 256; op++) begin
            command(8'(op));
            if (8'(op) == OPD) begin
                ride("R4 power-down entry", S_DEN, ENT_D, S_DPD);
                cs_n = 1'b0;
                repeat (PULSE) tick();
                cs_n = 1'b1;
                ride("R8 power-down wake", S_DWK, WK_D, S_IDLE);
            end else if (8'(op) == OPH) begin
                ride("R5 hibernate entry", S_HEN, ENT_H, S_HIB);
                tick();
                chk_state("R9 hibernate holds", S_HIB);
                cs_n = 1'b0;
                tick();
                cs_n = 1'b1;
                ride("R9 hibernate wake", S_HWK, WK_H, S_IDLE);
            end else begin
                chk_state("R3 other opcode", S_IDLE);
            end
            tick();
        end

        // Partial bytes of the power-down opcode: R3.
        for (int n = 0; n < 8; n++) begin
            cs_n = 1'b0;
            tick();
            send_bits(OPD, n);
            cs_n = 1'b1;
            tick();
            chk_state("R3 partial byte", S_IDLE);
            tick();
        end

        // Only the first byte counts: R11.
        cs_n = 1'b0;
        tick();
        send_bits(8'h00, 8);
        send_bits(OPD, 8);
        cs_n = 1'b1;
        tick();
        chk_state("R11 opcode in second byte", S_IDLE);
        tick();
        cs_n = 1'b0;
        tick();
        send_bits(OPH, 8);
        send_bits(8'hFF, 8);
        cs_n = 1'b1;
        tick();
        ride("R11 trailing bits ignored", S_HEN, ENT_H, S_HIB);
        cs_n = 1'b0;
        tick();
        cs_n = 1'b1;
        ride("R9 wake", S_HWK, WK_H, S_IDLE);

        // Wake pulse width sweep: R7.
        command(OPD);
        ride("R4 entry", S_DEN, ENT_D, S_DPD);
        for (int p = 1; p < PULSE; p++) begin
            cs_n = 1'b0;
            repeat (p) tick();
            cs_n = 1'b1;
            tick();
            chk_state("R7 short pulse", S_DPD);
        end
        cs_n = 1'b0;
        repeat (PULSE - 1) tick();
        chk_state("R7 one sample short", S_DPD);
        tick();
        // Select held low through the whole wake: R10.
        ride("R7 exact width wakes", S_DWK, WK_D, S_IDLE);
        tick(); tick();
        chk_state("R10 held select stays idle", S_IDLE);
        cs_n = 1'b1;
        tick();
        cs_n = 1'b0;
        tick();
        chk_state("R10 fresh select", S_SEL);
        cs_n = 1'b1;
        tick();

        // Select and clock activity during entry: R10.
        command(OPD);
        chk_state("R10 entry start", S_DEN);
        cs_n = 1'b0;
        sck = 1'b1;
        tick(); tick();
        cs_n = 1'b1;
        sck = 1'b0;
        tick();
        chk_state("R10 entry unaffected", S_DEN);
        tick();
        chk_state("R10 entry unaffected", S_DEN);
        tick();
        chk_state("R10 entry length kept", S_DPD);

        // Reset from a sleep state: R1.
        rst_n = 1'b0;
        tick();
        chk_state("R1 reset from sleep", S_IDLE);
        rst_n = 1'b1;
        tick();

        // Select toggling inside a hibernate wake: R10.
        command(OPH);
        ride("R5 entry", S_HEN, ENT_H, S_HIB);
        cs_n = 1'b0;
        tick();
        chk_state("R9 fall wakes", S_HWK);
        for (int i = 1; i < WK_H; i++) begin
            cs_n = (i % 2 == 1) ? 1'b1 : 1'b0;
            tick();
            chk_state("R10 wake toggles ignored", S_HWK);
        end
        cs_n = 1'b1;
        tick();
        chk_state("R10 wake ends on time", S_IDLE);

        summary();
        $finish;
    end

endmodule